// File: doc/BRIEF.md
# Synchronous Polled Bus Input Port

This block sits on a processor's shared parallel bus and lets software pull words from several hardware producers. Every producer offers a data word and a readiness pulse. A rising readiness pulse sets a per-producer ready flag. Software polls that flag at a status address until it is set, then reads the word at the producer's data address. That data read clears the flag again, so the producer and the reader stay in step one word at a time.

The bus read strobe and the readiness inputs come from outside the block's clock domain. Each passes through a two-flop synchroniser before the block uses it. A read gate opens only while the synchronised strobe is high and the address hits one of the port's addresses. While the gate is open, one tri-state driver places the selected word on the data lines. At all other times the lines float. A companion output shows when the lines are driven.

The address map is fixed by parameters. Data address `DATA_BASE+i` selects producer i. Status address `STAT_BASE+i` returns producer i's flag on bit 0.

Top module: `sbip_top`

## Requirements
- R1: After reset all ready flags are clear, the data lines are not driven (`bus_drive_o`=0), and every status read returns 0.
- R2: With `bus_rd_i` high and `bus_addr_i` = `DATA_BASE+i` (i < `NUM_SRC`), the port drives producer i's word, taken from `src_data_i[i*DATA_W +: DATA_W]`.
- R3: When `bus_rd_i` is low, or the address hits neither the data range nor the status range, `bus_drive_o` is 0 and the data lines are high impedance.
- R4: A rising edge on `src_rdy_i[i]` sets flag i, three clock edges after the input rises.
- R5: A read at `STAT_BASE+i` returns flag i on bit 0. All other bits are 0.
- R6: The rising edge of a data read gate at `DATA_BASE+i` clears flag i. A status read leaves every flag unchanged.
- R7: If a set edge and a clear edge on the same flag are seen at the same clock edge, the clear wins and the flag ends clear.
- R8: A flag changes only on edges. A `src_rdy_i` held high after its flag was cleared does not set the flag again until the input falls and rises once more.
- R9: The drive starts after the second rising clock edge that follows the rise of `bus_rd_i`, and stops after the second rising edge that follows its fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_data_i | input | NUM_SRC*DATA_W | Producer words, producer i in slice i |
| src_rdy_i | input | NUM_SRC | Asynchronous readiness pulses, one per producer |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_rd_i | input | 1 | Asynchronous bus read strobe, active high |
| bus_data_o | output | DATA_W | Tri-state bus data lines |
| bus_drive_o | output | 1 | High while bus_data_o is driven |

## Verification
A flag that is stuck or out of step shows at the next status poll, about three cycles after the read strobe rises. An extra set or clear shows the same way, as a wrong bit 0. A wrong selector or a stale gate shows at once as a wrong word, or as drive at the wrong time, because the bench compares drive and data with its model on every clock. The case of a set and a clear in one cycle is set up on purpose. So is a readiness input held high across a clear. Both show a wrong priority or a level-sensitive set at the next status read.

// File: rtl/sbip_pkg.sv
package sbip_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_DATA = 2'd1,
    HIT_STAT = 2'd2
  } hit_e;
endpackage

// File: rtl/sbip_sync.sv
module sbip_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/sbip_decode.sv
module sbip_decode
  import sbip_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_BASE = 0,
  parameter int STAT_BASE = 8,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_e              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  int unsigned a;
  always_comb begin
    a     = 32'(addr_i);
    hit_o = HIT_NONE;
    idx_o = '0;
    if (a >= DATA_BASE && a < DATA_BASE + NUM_SRC) begin
      hit_o = HIT_DATA;
      idx_o = IDX_W'(a - DATA_BASE);
    end else if (a >= STAT_BASE && a < STAT_BASE + NUM_SRC) begin
      hit_o = HIT_STAT;
      idx_o = IDX_W'(a - STAT_BASE);
    end
  end
endmodule

// File: rtl/sbip_flag.sv
module sbip_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_lvl_i,
  input  logic clr_lvl_i,
  output logic flag_o
);
  logic set_prev_q, clr_prev_q, flag_q;
  logic set_rise, clr_rise;

  assign set_rise = set_lvl_i & ~set_prev_q;
  assign clr_rise = clr_lvl_i & ~clr_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_prev_q <= 1'b0;
      clr_prev_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      set_prev_q <= set_lvl_i;
      clr_prev_q <= clr_lvl_i;
      if (clr_rise)      flag_q <= 1'b0; // clear has priority
      else if (set_rise) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lvl_i && !$past(clr_lvl_i)) |=> !flag_o); // R7
  AST_SET_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_lvl_i && !set_prev_q && !clr_lvl_i) |=> flag_o); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_lvl_i == set_prev_q || !set_lvl_i) && (clr_lvl_i == clr_prev_q || !clr_lvl_i))
      |=> $stable(flag_o)); // R8
endmodule

// File: rtl/sbip_top.sv
module sbip_top
  import sbip_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_BASE = 0,
  parameter int STAT_BASE = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*DATA_W-1:0] src_data_i,
  input  logic [NUM_SRC-1:0]        src_rdy_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic                      bus_rd_i,
  output logic [DATA_W-1:0]         bus_data_o,
  output logic                      bus_drive_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] rdy_s;
  logic               rd_s;
  hit_e               hit;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] flag;
  logic [NUM_SRC-1:0] clr_lvl;
  logic [DATA_W-1:0]  src_arr [NUM_SRC];
  logic [DATA_W-1:0]  word;
  logic               drive;

  sbip_sync #(.W(NUM_SRC)) u_rdy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_rdy_i), .q_o(rdy_s));

  sbip_sync #(.W(1)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_rd_i), .q_o(rd_s));

  sbip_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE),
    .STAT_BASE(STAT_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .addr_i(bus_addr_i), .hit_o(hit), .idx_o(idx));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_arr[i] = src_data_i[i*DATA_W +: DATA_W];
    assign clr_lvl[i] = rd_s && (hit == HIT_DATA) && (idx == IDX_W'(i));
    sbip_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_lvl_i(rdy_s[i]), .clr_lvl_i(clr_lvl[i]), .flag_o(flag[i]));
  end

  always_comb begin
    word = '0;
    if (hit == HIT_DATA)      word = src_arr[idx];
    else if (hit == HIT_STAT) word[0] = flag[idx];
  end

  assign drive       = rd_s && (hit != HIT_NONE);
  assign bus_drive_o = drive;
  assign bus_data_o  = drive ? word : {DATA_W{1'bz}};

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_s |-> !bus_drive_o); // R3
  AST_ONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_lvl)); // R6
  AST_STATUS_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == HIT_STAT) |-> (clr_lvl == '0)); // R6
  if (DATA_W > 1) begin : g_stat_chk
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drive && hit == HIT_STAT) |-> (bus_data_o[DATA_W-1:1] == '0)); // R5
  end
endmodule

// File: tb/tb_sbip_top.sv
`timescale 1ns/1ps
module tb_sbip_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int AW = 4;
  localparam int DB = 0;
  localparam int SB = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] src_data = '0;
  logic [N-1:0]   src_rdy = '0;
  logic [AW-1:0]  addr = '0;
  logic           rd = 1'b0;
  wire  [W-1:0]   bus_data;
  wire            bus_drive;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  sbip_top #(.NUM_SRC(N), .DATA_W(W), .ADDR_W(AW), .DATA_BASE(DB), .STAT_BASE(SB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_data_i(src_data), .src_rdy_i(src_rdy),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_data_o(bus_data), .bus_drive_o(bus_drive));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: delay lines and per-source flags
  logic         m_rd1, m_rd2, m_rdp;
  logic [N-1:0] m_s1, m_s2, m_sp, m_gp, m_flag;

  function automatic bit in_data(input int a);
    return a >= DB && a < DB + N;
  endfunction
  function automatic bit in_stat(input int a);
    return a >= SB && a < SB + N;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd1 <= 0; m_rd2 <= 0; m_rdp <= 0;
      m_s1 <= '0; m_s2 <= '0; m_sp <= '0; m_gp <= '0; m_flag <= '0;
    end else begin
      m_rd1 <= rd; m_rd2 <= m_rd1; m_rdp <= m_rd2;
      m_s1 <= src_rdy; m_s2 <= m_s1; m_sp <= m_s2;
      for (int i = 0; i < N; i++) begin
        bit g, c, s;
        g = m_rd2 && (int'(addr) == DB + i);
        c = g && !m_gp[i];
        s = m_s2[i] && !m_sp[i];
        m_gp[i] <= g;
        if (c)      m_flag[i] <= 1'b0;
        else if (s) m_flag[i] <= 1'b1;
      end
    end
  end

  // compare every cycle, settled, before the next rising edge
  always @(negedge clk) begin
    #2;
    if (!done) begin
      int a;
      bit ed;
      a  = int'(addr);
      ed = m_rd2 && (in_data(a) || in_stat(a));
      chk(bus_drive == ed, ed ? "R2/R9 drive" : "R3 no drive", bus_drive, ed);
      if (ed && bus_drive) begin
        if (in_data(a))
          chk(bus_data == src_data[(a-DB)*W +: W], "R2 word", bus_data, src_data[(a-DB)*W +: W]);
        else
          chk(bus_data == {{(W-1){1'b0}}, m_flag[a-SB]}, "R5 status", bus_data, m_flag[a-SB]);
      end
    end
  end

  task automatic do_read(input int a, output logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a);
    rd   = 1'b1;
    repeat (2) @(negedge clk);
    #2 d = bus_data;
    @(negedge clk);
    rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rdy(input int i);
    @(negedge clk);
    src_rdy[i] = 1'b1;
    repeat (2) @(negedge clk);
    src_rdy[i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    src_data = {8'hD4, 8'h3C, 8'hA5, 8'h17};
    repeat (4) @(negedge clk);
    chk(bus_drive == 1'b0, "R1 reset drive", bus_drive, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: all status clear after reset
    for (int i = 0; i < N; i++) begin
      do_read(SB + i, d);
      chk(d == 8'h00, "R1 status after reset", d, 0);
    end
    // R4/R5: set flag 1 and poll it
    pulse_rdy(1);
    do_read(SB + 1, d);
    chk(d == 8'h01, "R4 flag set", d, 1);
    do_read(SB + 0, d);
    chk(d == 8'h00, "R5 other flag clear", d, 0);
    // R6: status read keeps flag
    do_read(SB + 1, d);
    chk(d == 8'h01, "R6 status read no clear", d, 1);
    // R2/R6: data read returns word and clears flag
    do_read(DB + 1, d);
    chk(d == 8'hA5, "R2 data word src1", d, 8'hA5);
    do_read(SB + 1, d);
    chk(d == 8'h00, "R6 cleared by data read", d, 0);
    // R2: walk every source with fresh words
    src_data = {8'h81, 8'h42, 8'hFF, 8'h00};
    for (int i = 0; i < N; i++) begin
      pulse_rdy(i);
      do_read(SB + i, d);
      chk(d == 8'h01, "R4 flag set walk", d, 1);
      do_read(DB + i, d);
      chk(d == src_data[i*W +: W], "R2 data walk", d, src_data[i*W +: W]);
    end
    // R9: drive latency on rise and fall
    @(negedge clk);
    addr = AW'(DB + 2);
    rd   = 1'b1;
    @(negedge clk); #2;
    chk(bus_drive == 1'b0, "R9 no drive after one edge", bus_drive, 0);
    @(negedge clk); #2;
    chk(bus_drive == 1'b1, "R9 drive after two edges", bus_drive, 1);
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk); #2;
    chk(bus_drive == 1'b1, "R9 drive holds one edge", bus_drive, 1);
    @(negedge clk); #2;
    chk(bus_drive == 1'b0, "R9 drive off after two edges", bus_drive, 0);
    repeat (2) @(negedge clk);
    // R3: unmapped address and idle strobe
    @(negedge clk);
    addr = AW'(5);
    rd   = 1'b1;
    repeat (3) @(negedge clk); #2;
    chk(bus_drive == 1'b0, "R3 unmapped no drive", bus_drive, 0);
    @(negedge clk);
    rd   = 1'b0;
    addr = AW'(DB);
    repeat (4) @(negedge clk); #2;
    chk(bus_drive == 1'b0, "R3 idle no drive", bus_drive, 0);
    // R7: set and clear edge in the same cycle
    pulse_rdy(2);
    do_read(SB + 2, d);
    chk(d == 8'h01, "R7 precondition set", d, 1);
    @(negedge clk);
    addr       = AW'(DB + 2);
    rd         = 1'b1;
    src_rdy[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd         = 1'b0;
    src_rdy[2] = 1'b0;
    repeat (4) @(negedge clk);
    do_read(SB + 2, d);
    chk(d == 8'h00, "R7 clear wins", d, 0);
    // R8: held-high readiness does not re-set after clear
    @(negedge clk);
    src_rdy[3] = 1'b1;
    repeat (5) @(negedge clk);
    do_read(SB + 3, d);
    chk(d == 8'h01, "R8 edge sets", d, 1);
    do_read(DB + 3, d);
    repeat (6) @(negedge clk);
    do_read(SB + 3, d);
    chk(d == 8'h00, "R8 level does not re-set", d, 0);
    @(negedge clk);
    src_rdy[3] = 1'b0;
    repeat (3) @(negedge clk);
    pulse_rdy(3);
    do_read(SB + 3, d);
    chk(d == 8'h01, "R8 new edge sets", d, 1);
    // R1: reset clears flags
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(SB + 3, d);
    chk(d == 8'h00, "R1 reset clears flag", d, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule